// File: doc/BRIEF.md
# Tiled Image Address Calculator

This block turns a texel position (up to three coordinates) into a 32-bit byte offset inside a memory surface. The surface can be laid out linearly, in wide row-oriented tiles, or in tall column-oriented tiles. All layout choices come from run-time configuration inputs, so one netlist serves every layout. The configuration inputs are: shift amounts that give tile width and height, slice packing for volume images, two swizzle shift selectors and a swizzle enable.

Column-oriented tiling is treated as a row of narrow tiles placed side by side. A 4 KiB tile is seen as eight 512-byte sub-columns, and the tile shifts describe one sub-column. Volume images pack their depth slices in a grid. The low bits of z choose a horizontal slice position and the high bits choose a vertical slice row. The same path handles 2-D arrays when the depth shift is zero.

A request enters through a valid/ready handshake. Its result leaves through a second handshake after three pipeline stages. The whole pipeline moves together, so a stalled output holds every stage in place.

Top module: `tiled_addr_calc`

## Requirements
- R1: The adjusted coordinates are ax = off_x + x and ay = off_y + y. A coordinate whose index is not below `in_dims` (x is index 0, y is index 1) is replaced by zero, but its offset is still added.
- R2: When `in_dims` is 3, z is split into zmin = z mod 2^tile_z and zmaj = z >> tile_z. The value zmin × slice_h is added to ax and zmaj × slice_v is added to ay. The z coordinate receives no offset.
- R3: When `in_dims` is 2 or more, the values are mx = ax mod 2^tile_x, Mx = ax >> tile_x, my = ay mod 2^tile_y and My = ay >> tile_y.
- R4: When `in_dims` is 2 or more, the unswizzled offset is ((((Mx << tile_y) + my) << tile_x) + mx + (My << tile_y) × pitch) × bpp.
- R5: When `in_dims` is 0 or 1, the offset is (ax + ay × pitch) × bpp, and no swizzle is applied.
- R6: When swizzling is enabled and `in_dims` is 2 or more, bit 6 of the offset is XORed with bit 6 of (off >> sa) XOR (off >> sb). Here sa and sb are the low five bits of the 8-bit swizzle selectors, so 0xFF acts as 31 and removes that term. No other bit changes.
- R7: When `cfg_swz_en` is low, the output equals the unswizzled offset.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted request appears on `out_valid` two cycles after the accepting edge when no stall occurs. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_off` hold.
- R9: After a synchronous active-high reset, `out_valid` is low.
- R10: All arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_x | input | 32 | X coordinate |
| in_y | input | 32 | Y coordinate |
| in_z | input | 32 | Z (slice) coordinate |
| in_dims | input | 2 | Number of dimensions in use |
| cfg_off_x | input | 32 | Horizontal base offset in texels |
| cfg_off_y | input | 32 | Vertical base offset in texels |
| cfg_bpp | input | 32 | Bytes per texel |
| cfg_pitch | input | 32 | Row pitch in texels |
| cfg_slice_h | input | 32 | Horizontal spacing between packed slices |
| cfg_slice_v | input | 32 | Vertical spacing between packed slice rows |
| cfg_tile_x | input | 5 | log2 of tile (sub-column) width |
| cfg_tile_y | input | 5 | log2 of tile height |
| cfg_tile_z | input | 5 | log2 of slices per packed row |
| cfg_swz_a | input | 8 | First swizzle shift selector |
| cfg_swz_b | input | 8 | Second swizzle shift selector |
| cfg_swz_en | input | 1 | Swizzle enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready |
| out_off | output | 32 | Byte offset |

## Verification
Some properties are checked on every cycle. A stalled output must hold its value. A result may only appear when the middle stage held one. The minor indices of z and x must stay within their tile range. The swizzle stage may touch nothing but bit 6, and it must pass the product through unchanged when disabled. The arithmetic itself is covered only by the bench scenarios: the offset and dimension masking, slice packing, the tile index formula, the choice of swizzle bits, wrap-around and the exact latency. These scenarios compare results with an independent reference over linear, wide-tile, narrow-tile, volume and 1-D configurations.

// File: rtl/tac_pkg.sv
`timescale 1ns/1ps
package tac_pkg;
    localparam int AW   = 32;
    localparam int SHW  = 5;
    localparam int SELW = 8;
    localparam int DMW  = 2;
    localparam logic [AW-1:0] SWZ_BIT = 32'h0000_0040;

    typedef logic [AW-1:0]  word_t;
    typedef logic [SHW-1:0] shamt_t;

    typedef struct packed {
        logic [DMW-1:0] dims;
        word_t          ax;
        word_t          ay;
        shamt_t         tile_x;
        shamt_t         tile_y;
        word_t          pitch;
        word_t          bpp;
        shamt_t         swz_a;
        shamt_t         swz_b;
        logic           swz_en;
    } coord_t;

    typedef struct packed {
        logic   swz_on;
        word_t  lin;
        word_t  bpp;
        shamt_t swz_a;
        shamt_t swz_b;
    } linear_t;

    function automatic word_t low_part(word_t v, shamt_t n);
        return v & ((word_t'(1) << n) - word_t'(1));
    endfunction
endpackage

// File: rtl/tac_coord_stage.sv
`timescale 1ns/1ps
module tac_coord_stage
    import tac_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    input  logic           in_v,
    input  word_t          x,
    input  word_t          y,
    input  word_t          z,
    input  logic [DMW-1:0] dims,
    input  word_t          off_x,
    input  word_t          off_y,
    input  word_t          bpp,
    input  word_t          pitch,
    input  word_t          slice_h,
    input  word_t          slice_v,
    input  shamt_t         tile_x,
    input  shamt_t         tile_y,
    input  shamt_t         tile_z,
    input  logic [SELW-1:0] swz_a,
    input  logic [SELW-1:0] swz_b,
    input  logic           swz_en,
    output logic           v_q,
    output coord_t         c_q
);
    word_t  zmin, zmaj, ax, ay;
    coord_t c_d;

    always_comb begin
        zmin = low_part(z, tile_z);
        zmaj = z >> tile_z;
        ax   = off_x + ((dims > 2'd0) ? x : '0);
        ay   = off_y + ((dims > 2'd1) ? y : '0);
        if (dims > 2'd2) begin
            ax = ax + zmin * slice_h;
            ay = ay + zmaj * slice_v;
        end
        c_d.dims   = dims;
        c_d.ax     = ax;
        c_d.ay     = ay;
        c_d.tile_x = tile_x;
        c_d.tile_y = tile_y;
        c_d.pitch  = pitch;
        c_d.bpp    = bpp;
        c_d.swz_a  = swz_a[SHW-1:0];
        c_d.swz_b  = swz_b[SHW-1:0];
        c_d.swz_en = swz_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            c_q <= '0;
        end else if (adv) begin
            v_q <= in_v;
            c_q <= c_d;
        end
    end

    AST_ZMIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_v && dims == 2'd3) |-> ((zmin >> tile_z) == '0)); // R2
endmodule

// File: rtl/tac_tile_stage.sv
`timescale 1ns/1ps
module tac_tile_stage
    import tac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    in_v,
    input  coord_t  c,
    output logic    v_q,
    output linear_t l_q
);
    word_t   min_x, maj_x, min_y, maj_y, in_row, row_base;
    linear_t l_d;

    always_comb begin
        min_x    = low_part(c.ax, c.tile_x);
        maj_x    = c.ax >> c.tile_x;
        min_y    = low_part(c.ay, c.tile_y);
        maj_y    = c.ay >> c.tile_y;
        in_row   = (((maj_x << c.tile_y) + min_y) << c.tile_x) + min_x;
        row_base = (maj_y << c.tile_y) * c.pitch;
        l_d.bpp    = c.bpp;
        l_d.swz_a  = c.swz_a;
        l_d.swz_b  = c.swz_b;
        if (c.dims > 2'd1) begin
            l_d.lin    = row_base + in_row;
            l_d.swz_on = c.swz_en;
        end else begin
            l_d.lin    = c.ax + c.ay * c.pitch;
            l_d.swz_on = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            l_q <= '0;
        end else if (adv) begin
            v_q <= in_v;
            l_q <= l_d;
        end
    end

    AST_MINOR_X_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_v && c.dims > 2'd1) |-> ((min_x >> c.tile_x) == '0)); // R3
    AST_MINOR_Y_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_v && c.dims > 2'd1) |-> ((min_y >> c.tile_y) == '0)); // R3
endmodule

// File: rtl/tac_swz_stage.sv
`timescale 1ns/1ps
module tac_swz_stage
    import tac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    input  logic    in_v,
    input  linear_t l,
    output logic    v_q,
    output word_t   off_q
);
    word_t prod, flip, res;

    always_comb begin
        prod = l.lin * l.bpp;
        flip = ((prod >> l.swz_a) ^ (prod >> l.swz_b)) & SWZ_BIT;
        res  = l.swz_on ? (prod ^ flip) : prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            off_q <= '0;
        end else if (adv) begin
            v_q   <= in_v;
            off_q <= res;
        end
    end

    AST_SWZ_BIT6_ONLY: assert property (@(posedge clk) disable iff (rst)
        (adv && in_v) |=> (((off_q ^ $past(prod)) & ~SWZ_BIT) == '0)); // R6
    AST_SWZ_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (adv && in_v && !l.swz_on) |=> (off_q == $past(prod))); // R7
endmodule

// File: rtl/tiled_addr_calc.sv
`timescale 1ns/1ps
module tiled_addr_calc
    import tac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_x,
    input  logic [31:0] in_y,
    input  logic [31:0] in_z,
    input  logic [1:0]  in_dims,
    input  logic [31:0] cfg_off_x,
    input  logic [31:0] cfg_off_y,
    input  logic [31:0] cfg_bpp,
    input  logic [31:0] cfg_pitch,
    input  logic [31:0] cfg_slice_h,
    input  logic [31:0] cfg_slice_v,
    input  logic [4:0]  cfg_tile_x,
    input  logic [4:0]  cfg_tile_y,
    input  logic [4:0]  cfg_tile_z,
    input  logic [7:0]  cfg_swz_a,
    input  logic [7:0]  cfg_swz_b,
    input  logic        cfg_swz_en,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_off
);
    logic    adv, v1, v2, v3;
    coord_t  c1;
    linear_t l2;
    word_t   off3;

    assign adv      = out_ready || !v3;
    assign in_ready = adv;

    tac_coord_stage u_coord (
        .clk(clk), .rst(rst), .adv(adv), .in_v(in_valid),
        .x(in_x), .y(in_y), .z(in_z), .dims(in_dims),
        .off_x(cfg_off_x), .off_y(cfg_off_y), .bpp(cfg_bpp), .pitch(cfg_pitch),
        .slice_h(cfg_slice_h), .slice_v(cfg_slice_v),
        .tile_x(cfg_tile_x), .tile_y(cfg_tile_y), .tile_z(cfg_tile_z),
        .swz_a(cfg_swz_a), .swz_b(cfg_swz_b), .swz_en(cfg_swz_en),
        .v_q(v1), .c_q(c1)
    );

    tac_tile_stage u_tile (
        .clk(clk), .rst(rst), .adv(adv), .in_v(v1), .c(c1),
        .v_q(v2), .l_q(l2)
    );

    tac_swz_stage u_swz (
        .clk(clk), .rst(rst), .adv(adv), .in_v(v2), .l(l2),
        .v_q(v3), .off_q(off3)
    );

    assign out_valid = v3;
    assign out_off   = off3;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_off))); // R8
    AST_OUT_FROM_PIPE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(v2)); // R8
endmodule

// File: tb/test_tiled_addr_calc.sv
`timescale 1ns/1ps
module test_tiled_addr_calc;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        in_valid = 0, out_ready = 1, in_ready, out_valid;
    logic [31:0] in_x = 0, in_y = 0, in_z = 0, out_off;
    logic [1:0]  in_dims = 0;
    logic [31:0] off_x = 0, off_y = 0, bpp = 1, pitch = 0, sl_h = 0, sl_v = 0;
    logic [4:0]  tx = 0, ty = 0, tz = 0;
    logic [7:0]  sa = 8'hff, sb = 8'hff;
    logic        swz_en = 0;

    int n_chk = 0, n_fail = 0;

    tiled_addr_calc i_tiled_addr_calc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_dims(in_dims),
        .cfg_off_x(off_x), .cfg_off_y(off_y), .cfg_bpp(bpp), .cfg_pitch(pitch),
        .cfg_slice_h(sl_h), .cfg_slice_v(sl_v),
        .cfg_tile_x(tx), .cfg_tile_y(ty), .cfg_tile_z(tz),
        .cfg_swz_a(sa), .cfg_swz_b(sb), .cfg_swz_en(swz_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_off(out_off)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input logic [31:0] v, input logic [4:0] n);
        logic [31:0] r = 0;
        for (int i = 0; i < 32; i++) if (i < int'(n)) r[i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] ref_off(input logic [31:0] x, y, z, input logic [1:0] d);
        logic [31:0] ax, ay, b, t;
        ax = off_x + ((d >= 1) ? x : 32'd0);
        ay = off_y + ((d >= 2) ? y : 32'd0);
        if (d == 3) begin
            ax += msk(z, tz) * sl_h;
            ay += (z >> tz) * sl_v;
        end
        if (d >= 2) begin
            b = ((((ax >> tx) << ty) + msk(ay, ty)) << tx) + msk(ax, tx);
            b = (b + ((ay >> ty) << ty) * pitch) * bpp;
            if (swz_en) begin
                t = (b >> sa[4:0]) ^ (b >> sb[4:0]);
                b[6] = b[6] ^ t[6];
            end
        end else begin
            b = (ax + ay * pitch) * bpp;
        end
        return b;
    endfunction

    // Sends one request, returns result and cycles from accepting edge's negedge to out_valid.
    task automatic send(input logic [31:0] x, y, z, input logic [1:0] d,
                        output logic [31:0] res, output int lat);
        @(negedge clk);
        in_x = x; in_y = y; in_z = z; in_dims = d; in_valid = 1; out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        lat = 0;
        while (!out_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        res = out_off;
    endtask

    task automatic run(input logic [31:0] x, y, z, input logic [1:0] d, input string req);
        logic [31:0] r, e;
        int lat;
        e = ref_off(x, y, z, d);
        send(x, y, z, d, r, lat);
        check(r === e, req, r, e);
    endtask

    task automatic t_reset();
        check(out_valid === 1'b0, "R9", 32'(out_valid), 32'd0);
        check(in_ready === 1'b1, "R8", 32'(in_ready), 32'd1);
    endtask

    task automatic t_latency();
        logic [31:0] r;
        int lat;
        off_x = 0; off_y = 0; bpp = 4; pitch = 16; tx = 0; ty = 0; swz_en = 0;
        send(32'd3, 32'd2, 0, 2'd2, r, lat);
        check(lat == 2, "R8", 32'(lat), 32'd2);
        check(r == 32'd140, "R4", r, 32'd140);
    endtask

    task automatic t_one_dim();
        off_x = 5; off_y = 2; bpp = 4; pitch = 100; swz_en = 1; sa = 8'd3; sb = 8'hff;
        run(32'd7, 32'd999, 32'd55, 2'd1, "R5");   // y ignored, off_y kept, no swizzle
        check(ref_off(32'd7, 32'd999, 32'd55, 2'd1) == 32'd848, "R1", ref_off(32'd7, 32'd999, 32'd55, 2'd1), 32'd848);
        run(32'd7, 32'd1, 32'd0, 2'd0, "R1");      // x also ignored
        swz_en = 0;
    endtask

    task automatic t_swizzle();
        logic [31:0] r;
        int lat;
        off_x = 0; off_y = 0; bpp = 1; pitch = 1024; tx = 0; ty = 0; swz_en = 1;
        sa = 8'd3; sb = 8'hff;
        send(32'h200, 0, 0, 2'd2, r, lat);
        check(r == 32'h240, "R6", r, 32'h240);
        sa = 8'd3; sb = 8'd4;
        send(32'h600, 0, 0, 2'd2, r, lat);
        check(r == 32'h600, "R6", r, 32'h600);
        sa = 8'hff; sb = 8'hff;
        send(32'h3c0, 0, 0, 2'd2, r, lat);
        check(r == 32'h3c0, "R6", r, 32'h3c0);
        sa = 8'd3; sb = 8'hff; swz_en = 0;
        send(32'h200, 0, 0, 2'd2, r, lat);
        check(r == 32'h200, "R7", r, 32'h200);
    endtask

    task automatic t_wrap();
        logic [31:0] r;
        int lat;
        off_x = 0; off_y = 0; bpp = 2; pitch = 0; swz_en = 0;
        send(32'h8000_0003, 0, 0, 2'd1, r, lat);
        check(r == 32'd6, "R10", r, 32'd6);
    endtask

    task automatic t_random(input logic [4:0] ftx, fty, input logic [7:0] fa, fb, input string req);
        tx = ftx; ty = fty; bpp = 4; pitch = 512; off_x = 3; off_y = 1;
        sa = fa; sb = fb; swz_en = 1;
        for (int i = 0; i < 30; i++)
            run($urandom_range(0, 4000), $urandom_range(0, 4000), 0, 2'd2, req);
    endtask

    task automatic t_volume();
        tx = 2; ty = 5; tz = 2; bpp = 4; pitch = 256; sl_h = 64; sl_v = 32;
        off_x = 1; off_y = 0; sa = 8'd3; sb = 8'hff; swz_en = 1;
        run(32'd5, 32'd7, 32'd6, 2'd3, "R2");
        for (int i = 0; i < 20; i++)
            run($urandom_range(0, 60), $urandom_range(0, 30), $urandom_range(0, 15), 2'd3, "R2");
        tz = 0;
        run(32'd9, 32'd4, 32'd3, 2'd3, "R2");
    endtask

    task automatic t_stall();
        logic [31:0] e, held;
        off_x = 0; off_y = 0; bpp = 8; pitch = 32; tx = 3; ty = 2; swz_en = 0;
        e = ref_off(32'd21, 32'd9, 0, 2'd2);
        @(negedge clk);
        out_ready = 0; in_x = 21; in_y = 9; in_dims = 2; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        repeat (4) @(negedge clk);
        check(out_valid === 1'b1, "R8", 32'(out_valid), 32'd1);
        check(in_ready === 1'b0, "R8", 32'(in_ready), 32'd0);
        held = out_off;
        check(held == e, "R8", held, e);
        @(negedge clk);
        check(out_off == held, "R8", out_off, held);
        out_ready = 1;
        @(negedge clk);
        check(out_valid === 1'b0, "R8", 32'(out_valid), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_one_dim();
        t_swizzle();
        t_wrap();
        t_random(5'd0, 5'd0, 8'hff, 8'hff, "R4");  // linear
        t_random(5'd7, 5'd3, 8'd3, 8'd4, "R3");    // wide tiles, two-term swizzle
        t_random(5'd2, 5'd5, 8'd3, 8'hff, "R6");   // narrow sub-column tiles
        t_volume();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule